// File: doc/BRIEF.md
# SDRAM Low-Power Sequencer

This block sits on the controller side of a single-rank SDR SDRAM. It moves the memory into and out of three CKE-driven low-power states: self refresh, power down and clock suspend. Host logic sends one-cycle request pulses to enter or leave each state. The sequencer drives the clock-enable and the four command strobes (chip select, row strobe, column strobe, write enable), and reports `busy` during transitions and `ready` when the bus is back in normal operation.

Each state has its own entry condition and its own exit delay. Self refresh requires every bank to be idle. Clock suspend requires at least one bank to be open. Power down is allowed at any time, but it is timed against the refresh period and left automatically before that period runs out. All delays are parameters counted in clock cycles, and one down-counter serves every timed wait. When the host refreshes in bursts, the sequencer asks an external refresh engine for a burst before it enters self refresh and again after it leaves, and waits for that engine to finish each time.

Top module: `sdram_lp_seq`

## Requirements
- R1: A self-refresh entry drives, for exactly one cycle, sd_cke=0, sd_cs_n=0, sd_ras_n=0, sd_cas_n=0, sd_we_n=1. From the next cycle, CKE stays low and the command bus shows deselect (sd_cs_n=1).
- R2: A self-refresh request made while banks_idle is 0 is refused. A clock-suspend request made while banks_idle is 1 is also refused. A refusal gives a one-cycle req_refused pulse in the cycle after the request, and the bus stays in normal mode with CKE high.
- R3: CKE stays low for as long as the memory rests in self refresh. The cycle after a self-refresh exit request is registered, CKE is high.
- R4: After CKE rises on a self-refresh exit, exactly SRX_CYC cycles pass with CKE high and only NOP or deselect on the bus before ready returns. lp_mode encodes 0 normal, 1 self refresh, 2 power down, 3 clock suspend.
- R5: With batch_refresh high, rfsh_req is held before self-refresh entry until rfsh_done arrives while banks_idle is 1. It is held again after the exit delay until rfsh_done arrives, and only then does ready return. With batch_refresh low, rfsh_req stays 0.
- R6: In power down, CKE is low for at most PD_MAX_CYC cycles. If no exit is requested, CKE rises after exactly PD_MAX_CYC cycles, and pd_forced_exit pulses in that same cycle. An exit requested by the host does not pulse pd_forced_exit.
- R7: In the first cycle after CKE rises on a power-down exit, the bus carries a NOP. Exactly PDX_CYC cycles with CKE high pass before ready returns.
- R8: Clock suspend drives CKE low with deselect on the bus and lp_mode=3. A resume request gives one busy cycle with CKE high and a NOP, and ready returns after that cycle.
- R9: NOP is sd_cs_n=0 with sd_ras_n, sd_cas_n and sd_we_n all 1, and deselect is sd_cs_n=1. After reset the block shows CKE high, a NOP, ready=1, busy=0 and lp_mode=0.
- R10: busy is high only during transitions and is never high together with ready. Requests that arrive while busy, or that do not match the current resting state, are ignored.
- R11: When several entry requests arrive in the same normal cycle, self refresh wins over power down, and power down wins over clock suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle | input | 1 | All banks are precharged |
| batch_refresh | input | 1 | Host refreshes in bursts; ask for bursts around self refresh |
| rfsh_done | input | 1 | External refresh burst finished |
| req_sr_enter | input | 1 | Request self-refresh entry |
| req_sr_exit | input | 1 | Request self-refresh exit |
| req_pd_enter | input | 1 | Request power-down entry |
| req_pd_exit | input | 1 | Request power-down exit |
| req_clk_suspend | input | 1 | Request clock suspend |
| req_clk_resume | input | 1 | Request clock resume |
| busy | output | 1 | Transition in progress |
| ready | output | 1 | Normal mode, bus free for commands |
| lp_mode | output | 2 | Current mode code |
| rfsh_req | output | 1 | Asks for a refresh burst |
| req_refused | output | 1 | One-cycle pulse for a refused request |
| pd_forced_exit | output | 1 | Power down left on the refresh-period limit |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |

## Verification
The bench leaves power down at every point in its allowed window, from the first cycle to one cycle before the limit, and also lets it run into the limit. The early exits show that pd_forced_exit stays low when the host ends power down. The run to the limit shows that the exit comes after exactly PD_MAX_CYC cycles. Self refresh is driven in both unbatched and batched form. In batched form the refresh-done signal is withheld, and also sent while the banks are busy, which separates a correct handshake from an early entry. Refusals, requests sent during a transition, and simultaneous entry requests check the bank-state conditions and the priority order.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  typedef enum logic [3:0] {
    ST_NORM,
    ST_PRE_RF,
    ST_SR_ENTRY,
    ST_SR,
    ST_SR_EXIT,
    ST_POST_RF,
    ST_PD,
    ST_PD_EXIT,
    ST_SUSP,
    ST_SUSP_EXIT
  } lp_state_e;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_SELF_RF = 2'd1,
    MODE_PWR_DN  = 2'd2,
    MODE_SUSPEND = 2'd3
  } lp_mode_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_DESEL   = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_SELF_RF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  function automatic lp_mode_e mode_of(lp_state_e s);
    case (s)
      ST_SR_ENTRY, ST_SR, ST_SR_EXIT, ST_POST_RF: mode_of = MODE_SELF_RF;
      ST_PD, ST_PD_EXIT:                          mode_of = MODE_PWR_DN;
      ST_SUSP, ST_SUSP_EXIT:                      mode_of = MODE_SUSPEND;
      default:                                    mode_of = MODE_NORMAL;
    endcase
  endfunction

  function automatic logic busy_of(lp_state_e s);
    case (s)
      ST_PRE_RF, ST_SR_ENTRY, ST_SR_EXIT, ST_POST_RF,
      ST_PD_EXIT, ST_SUSP_EXIT: busy_of = 1'b1;
      default:                  busy_of = 1'b0;
    endcase
  endfunction

  function automatic logic cke_of(lp_state_e s);
    case (s)
      ST_SR_ENTRY, ST_SR, ST_PD, ST_SUSP: cke_of = 1'b0;
      default:                            cke_of = 1'b1;
    endcase
  endfunction

  function automatic sd_cmd_t cmd_of(lp_state_e s);
    case (s)
      ST_SR_ENTRY:             cmd_of = CMD_SELF_RF;
      ST_SR, ST_PD, ST_SUSP:   cmd_of = CMD_DESEL;
      default:                 cmd_of = CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/lp_wait_timer.sv
module lp_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // the count only moves down between loads
  AST_TMR_DOWN_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$past(load) && !$past(rst) |-> cnt_q <= $past(cnt_q)); // R4

endmodule

// File: rtl/lp_ctrl_fsm.sv
module lp_ctrl_fsm
  import sdram_lp_pkg::*;
#(
  parameter int SRX_CYC    = 14,
  parameter int PD_MAX_CYC = 1560,
  parameter int PDX_CYC    = 2,
  parameter int W          = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         banks_idle,
  input  logic         batch_refresh,
  input  logic         rfsh_done,
  input  logic         req_sr_enter,
  input  logic         req_sr_exit,
  input  logic         req_pd_enter,
  input  logic         req_pd_exit,
  input  logic         req_clk_suspend,
  input  logic         req_clk_resume,
  input  logic         tmr_expired,
  output lp_state_e    state_q,
  output lp_state_e    state_d,
  output logic         tmr_load,
  output logic [W-1:0] tmr_val,
  output logic         refuse_d,
  output logic         forced_d
);

  localparam logic [W-1:0] SRX_LOAD  = W'(SRX_CYC - 1);
  localparam logic [W-1:0] PDM_LOAD  = W'(PD_MAX_CYC - 1);
  localparam logic [W-1:0] PDX_LOAD  = W'(PDX_CYC - 1);

  always_comb begin
    state_d  = state_q;
    refuse_d = 1'b0;
    forced_d = 1'b0;
    case (state_q)
      ST_NORM: begin
        if (req_sr_enter) begin
          if (banks_idle) state_d = batch_refresh ? ST_PRE_RF : ST_SR_ENTRY;
          else            refuse_d = 1'b1;
        end else if (req_pd_enter) begin
          state_d = ST_PD;
        end else if (req_clk_suspend) begin
          if (!banks_idle) state_d = ST_SUSP;
          else             refuse_d = 1'b1;
        end
      end
      ST_PRE_RF:    if (rfsh_done && banks_idle) state_d = ST_SR_ENTRY;
      ST_SR_ENTRY:  state_d = ST_SR;
      ST_SR:        if (req_sr_exit) state_d = ST_SR_EXIT;
      ST_SR_EXIT:   if (tmr_expired) state_d = batch_refresh ? ST_POST_RF : ST_NORM;
      ST_POST_RF:   if (rfsh_done) state_d = ST_NORM;
      ST_PD: begin
        if (req_pd_exit || tmr_expired) begin
          state_d  = ST_PD_EXIT;
          forced_d = !req_pd_exit;
        end
      end
      ST_PD_EXIT:   if (tmr_expired) state_d = ST_NORM;
      ST_SUSP:      if (req_clk_resume) state_d = ST_SUSP_EXIT;
      ST_SUSP_EXIT: state_d = ST_NORM;
      default:      state_d = ST_NORM;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    case (state_d)
      ST_SR_EXIT: tmr_val = SRX_LOAD;
      ST_PD:      tmr_val = PDM_LOAD;
      ST_PD_EXIT: tmr_val = PDX_LOAD;
      default:    tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_NORM;
    else     state_q <= state_d;
  end

  AST_SR_FROM_REST_ONLY: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_SR_EXIT |-> $past(state_q) inside {ST_SR, ST_SR_EXIT}); // R10

  AST_SUSP_NEEDS_OPEN_BANK: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_SUSP && $past(state_q) == ST_NORM |-> !$past(banks_idle)); // R8

endmodule

// File: rtl/lp_cmd_drive.sv
module lp_cmd_drive
  import sdram_lp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lp_state_e state_d,
  input  logic      refuse_d,
  input  logic      forced_d,
  output logic      busy,
  output logic      ready,
  output logic [1:0] lp_mode,
  output logic      rfsh_req,
  output logic      req_refused,
  output logic      pd_forced_exit,
  output logic      sd_cke,
  output logic      sd_cs_n,
  output logic      sd_ras_n,
  output logic      sd_cas_n,
  output logic      sd_we_n
);

  sd_cmd_t cmd_d;
  assign cmd_d = cmd_of(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy           <= 1'b0;
      ready          <= 1'b1;
      lp_mode        <= MODE_NORMAL;
      rfsh_req       <= 1'b0;
      req_refused    <= 1'b0;
      pd_forced_exit <= 1'b0;
      sd_cke         <= 1'b1;
      sd_cs_n        <= CMD_NOP.cs_n;
      sd_ras_n       <= CMD_NOP.ras_n;
      sd_cas_n       <= CMD_NOP.cas_n;
      sd_we_n        <= CMD_NOP.we_n;
    end else begin
      busy           <= busy_of(state_d);
      ready          <= (state_d == ST_NORM);
      lp_mode        <= mode_of(state_d);
      rfsh_req       <= (state_d == ST_PRE_RF) || (state_d == ST_POST_RF);
      req_refused    <= refuse_d;
      pd_forced_exit <= forced_d;
      sd_cke         <= cke_of(state_d);
      sd_cs_n        <= cmd_d.cs_n;
      sd_ras_n       <= cmd_d.ras_n;
      sd_cas_n       <= cmd_d.cas_n;
      sd_we_n        <= cmd_d.we_n;
    end
  end

  AST_RFSH_ONLY_SR: assert property (@(posedge clk) disable iff (rst)
    rfsh_req |-> lp_mode inside {MODE_NORMAL, MODE_SELF_RF}); // R5

endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import sdram_lp_pkg::*;
#(
  parameter int SRX_CYC    = 14,
  parameter int PD_MAX_CYC = 1560,
  parameter int PDX_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       banks_idle,
  input  logic       batch_refresh,
  input  logic       rfsh_done,
  input  logic       req_sr_enter,
  input  logic       req_sr_exit,
  input  logic       req_pd_enter,
  input  logic       req_pd_exit,
  input  logic       req_clk_suspend,
  input  logic       req_clk_resume,
  output logic       busy,
  output logic       ready,
  output logic [1:0] lp_mode,
  output logic       rfsh_req,
  output logic       req_refused,
  output logic       pd_forced_exit,
  output logic       sd_cke,
  output logic       sd_cs_n,
  output logic       sd_ras_n,
  output logic       sd_cas_n,
  output logic       sd_we_n
);

  localparam int T_MAX_AB = (SRX_CYC > PDX_CYC) ? SRX_CYC : PDX_CYC;
  localparam int T_MAX    = (T_MAX_AB > PD_MAX_CYC) ? T_MAX_AB : PD_MAX_CYC;
  localparam int W        = $clog2(T_MAX + 1);

  lp_state_e    state_q, state_d;
  logic         tmr_load, tmr_expired, refuse_d, forced_d;
  logic [W-1:0] tmr_val;

  lp_ctrl_fsm #(
    .SRX_CYC(SRX_CYC), .PD_MAX_CYC(PD_MAX_CYC), .PDX_CYC(PDX_CYC), .W(W)
  ) i_fsm (
    .clk(clk), .rst(rst), .banks_idle(banks_idle), .batch_refresh(batch_refresh),
    .rfsh_done(rfsh_done), .req_sr_enter(req_sr_enter), .req_sr_exit(req_sr_exit),
    .req_pd_enter(req_pd_enter), .req_pd_exit(req_pd_exit),
    .req_clk_suspend(req_clk_suspend), .req_clk_resume(req_clk_resume),
    .tmr_expired(tmr_expired), .state_q(state_q), .state_d(state_d),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .refuse_d(refuse_d), .forced_d(forced_d)
  );

  lp_wait_timer #(.W(W)) i_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  lp_cmd_drive i_drive (
    .clk(clk), .rst(rst), .state_d(state_d), .refuse_d(refuse_d), .forced_d(forced_d),
    .busy(busy), .ready(ready), .lp_mode(lp_mode), .rfsh_req(rfsh_req),
    .req_refused(req_refused), .pd_forced_exit(pd_forced_exit), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n)
  );

  // checker state: consecutive cycles spent with CKE low in power down
  logic [W:0] pd_low_cnt;
  logic       sr_cmd_now;

  always_ff @(posedge clk) begin
    if (rst)                                      pd_low_cnt <= '0;
    else if (lp_mode == MODE_PWR_DN && !sd_cke)   pd_low_cnt <= pd_low_cnt + 1'b1;
    else                                          pd_low_cnt <= '0;
  end

  assign sr_cmd_now = !sd_cke && !sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n;

  AST_SR_ENTRY_IDLE: assert property (@(posedge clk) disable iff (rst)
    sr_cmd_now |-> $past(banks_idle)); // R2

  AST_SR_ENTRY_ONE: assert property (@(posedge clk) disable iff (rst)
    sr_cmd_now |=> !sr_cmd_now && !sd_cke && sd_cs_n); // R1

  AST_SR_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
    lp_mode == MODE_SELF_RF && !busy |-> !sd_cke); // R3

  AST_CKE_RISE_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_cke) |-> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n)); // R7

  AST_PD_DWELL: assert property (@(posedge clk) disable iff (rst)
    pd_low_cnt <= (W+1)'(PD_MAX_CYC)); // R6

  AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && ready)); // R10

  AST_REFUSE_STAYS: assert property (@(posedge clk) disable iff (rst)
    req_refused |-> ready && sd_cke && lp_mode == MODE_NORMAL); // R2

endmodule

// File: tb/test_sdram_lp_seq.sv
`timescale 1ns/1ps
module test_sdram_lp_seq;

  localparam int SRX  = 5;
  localparam int PDM  = 12;
  localparam int PDX  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic banks_idle = 1'b1, batch_refresh = 1'b0, rfsh_done = 1'b0;
  logic req_sr_enter = 1'b0, req_sr_exit = 1'b0, req_pd_enter = 1'b0, req_pd_exit = 1'b0;
  logic req_clk_suspend = 1'b0, req_clk_resume = 1'b0;
  logic busy, ready, rfsh_req, req_refused, pd_forced_exit;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] lp_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  sdram_lp_seq #(.SRX_CYC(SRX), .PD_MAX_CYC(PDM), .PDX_CYC(PDX)) i_sdram_lp_seq (
    .clk(clk), .rst(rst), .banks_idle(banks_idle), .batch_refresh(batch_refresh),
    .rfsh_done(rfsh_done), .req_sr_enter(req_sr_enter), .req_sr_exit(req_sr_exit),
    .req_pd_enter(req_pd_enter), .req_pd_exit(req_pd_exit),
    .req_clk_suspend(req_clk_suspend), .req_clk_resume(req_clk_resume),
    .busy(busy), .ready(ready), .lp_mode(lp_mode), .rfsh_req(rfsh_req),
    .req_refused(req_refused), .pd_forced_exit(pd_forced_exit), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bus4();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  function automatic bit is_nop();
    return !sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n;
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // brings self refresh up and down without batching; leaves bus ready
  task automatic sr_round(input string tag);
    int n;
    req_sr_enter = 1; step(); req_sr_enter = 0;
    chk(!sd_cke && bus4() == 4'b0001, {tag, " R1 entry cmd"}, bus4(), 1);
    step();
    chk(!sd_cke && sd_cs_n && !busy, {tag, " R1 rest deselect"}, {sd_cke, sd_cs_n}, 1);
    req_sr_exit = 1; step(); req_sr_exit = 0;
    n = 0;
    while (!ready && n < 100) begin n++; step(); end
    chk(n == SRX, {tag, " R4 exit length"}, n, SRX);
  endtask

  initial begin
    int n, m;
    repeat (3) step();
    rst = 0;
    step();
    // R9 reset state
    chk(sd_cke && is_nop(), "R9 reset bus", bus4(), 4'b0111);
    chk(ready && !busy && lp_mode == 0, "R9 reset status", {ready, busy, lp_mode}, 4'b1000);

    // R1 R3 R4: unbatched self refresh
    banks_idle = 1;
    req_sr_enter = 1; step(); req_sr_enter = 0;
    chk(!sd_cke && bus4() == 4'b0001, "R1 entry encoding", {sd_cke, bus4()}, 5'b00001);
    chk(busy && lp_mode == 1, "R1 entry busy", {busy, lp_mode}, 3'b101);
    step();
    chk(!sd_cke && sd_cs_n, "R1 deselect after entry", {sd_cke, sd_cs_n}, 1);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(!sd_cke && !busy && !ready, "R3 cke held low", sd_cke, 0);
    end
    req_pd_enter = 1; step(); req_pd_enter = 0;
    chk(!sd_cke && lp_mode == 1, "R10 pd request ignored in self refresh", lp_mode, 1);
    req_sr_exit = 1; step(); req_sr_exit = 0;
    chk(sd_cke, "R3 cke high after exit request", sd_cke, 1);
    n = 0;
    while (!ready && n < 100) begin
      n++;
      chk(sd_cke && (is_nop() || sd_cs_n) && !rfsh_req, "R4 idle bus in exit", bus4(), 4'b0111);
      step();
    end
    chk(n == SRX, "R4 exit delay cycles", n, SRX);
    chk(lp_mode == 0 && !busy, "R4 back to normal", lp_mode, 0);

    // R2: refusals
    banks_idle = 0;
    req_sr_enter = 1; step(); req_sr_enter = 0;
    chk(req_refused && sd_cke && lp_mode == 0 && ready, "R2 sr refused with open bank", req_refused, 1);
    step();
    chk(!req_refused && sd_cke, "R2 refusal single cycle", req_refused, 0);
    banks_idle = 1;
    req_clk_suspend = 1; step(); req_clk_suspend = 0;
    chk(req_refused && sd_cke && lp_mode == 0, "R2 suspend refused with idle banks", req_refused, 1);
    step();

    // R6 R7: power down run into the limit
    req_pd_enter = 1; step(); req_pd_enter = 0;
    n = 0;
    while (!sd_cke && n < 100) begin
      n++;
      chk(lp_mode == 2 && sd_cs_n, "R6 power down resting", lp_mode, 2);
      step();
    end
    chk(n == PDM, "R6 forced exit time", n, PDM);
    chk(pd_forced_exit, "R6 forced flag", pd_forced_exit, 1);
    chk(is_nop(), "R7 nop after cke rise", bus4(), 4'b0111);
    m = 0;
    while (!ready && m < 100) begin m++; step(); end
    chk(m == PDX, "R7 exit cycles forced", m, PDX);

    // R6 R7: host exit at every point of the window
    for (int k = 1; k < PDM; k++) begin
      req_pd_enter = 1; step(); req_pd_enter = 0;
      n = 1;
      while (n < k) begin
        chk(!sd_cke, "R6 cke low before exit", sd_cke, 0);
        step(); n++;
      end
      chk(!sd_cke, "R6 cke low at exit request", sd_cke, 0);
      req_pd_exit = 1; step(); req_pd_exit = 0;
      chk(sd_cke && !pd_forced_exit, "R6 host exit not forced", {sd_cke, pd_forced_exit}, 2);
      chk(is_nop() && busy, "R7 nop first exit cycle", bus4(), 4'b0111);
      m = 0;
      while (!ready && m < 100) begin
        chk(sd_cke, "R7 cke held high", sd_cke, 1);
        m++; step();
      end
      chk(m == PDX, "R7 exit cycles host", m, PDX);
    end

    // R8: clock suspend
    banks_idle = 0;
    req_clk_suspend = 1; step(); req_clk_suspend = 0;
    chk(!sd_cke && lp_mode == 3 && sd_cs_n && !busy, "R8 suspend entry", {sd_cke, lp_mode}, 3);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(!sd_cke && lp_mode == 3, "R8 suspend held", sd_cke, 0);
    end
    req_clk_resume = 1; step(); req_clk_resume = 0;
    chk(sd_cke && busy && is_nop() && !ready, "R8 resume cycle", {sd_cke, busy}, 3);
    step();
    chk(ready && lp_mode == 0, "R8 ready after one cycle", ready, 1);
    banks_idle = 1;

    // R5: batched self refresh
    batch_refresh = 1;
    req_sr_enter = 1; step(); req_sr_enter = 0;
    chk(rfsh_req && sd_cke && busy && lp_mode == 0, "R5 pre burst request", rfsh_req, 1);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(rfsh_req && sd_cke, "R5 waits for burst", sd_cke, 1);
    end
    banks_idle = 0; rfsh_done = 1; step();
    chk(sd_cke && rfsh_req, "R5 no entry with open bank", sd_cke, 1);
    banks_idle = 1; step(); rfsh_done = 0;
    chk(!sd_cke && bus4() == 4'b0001 && !rfsh_req, "R5 entry after burst", bus4(), 1);
    step();
    req_sr_exit = 1; step(); req_sr_exit = 0;
    n = 0;
    while (!rfsh_req && n < 100) begin
      chk(sd_cke && !ready, "R5 exit delay before post burst", ready, 0);
      n++; step();
    end
    chk(n == SRX, "R5 post burst after delay", n, SRX);
    for (int i = 0; i < 2; i++) begin
      chk(rfsh_req && !ready && busy, "R5 waits post burst", ready, 0);
      step();
    end
    rfsh_done = 1; step(); rfsh_done = 0;
    chk(ready && !rfsh_req && lp_mode == 0, "R5 ready after post burst", ready, 1);
    batch_refresh = 0;
    step();

    // R10: requests during a transition are ignored
    req_sr_enter = 1; step(); req_sr_enter = 0;
    step();
    req_sr_exit = 1; step(); req_sr_exit = 0;
    n = 0;
    while (!ready && n < 100) begin
      req_pd_enter = busy;
      n++; step();
    end
    req_pd_enter = 0;
    chk(n == SRX, "R10 exit length with stray request", n, SRX);
    step();
    chk(sd_cke && lp_mode == 0 && ready, "R10 request while busy ignored", lp_mode, 0);

    // R11: priority
    req_sr_enter = 1; req_pd_enter = 1; req_clk_suspend = 1; step();
    req_sr_enter = 0; req_pd_enter = 0; req_clk_suspend = 0;
    chk(bus4() == 4'b0001 && lp_mode == 1, "R11 self refresh wins", lp_mode, 1);
    step();
    req_sr_exit = 1; step(); req_sr_exit = 0;
    n = 0;
    while (!ready && n < 100) begin n++; step(); end
    banks_idle = 0;
    req_pd_enter = 1; req_clk_suspend = 1; step();
    req_pd_enter = 0; req_clk_suspend = 0;
    chk(lp_mode == 2 && !sd_cke, "R11 power down beats suspend", lp_mode, 2);
    req_pd_exit = 1; step(); req_pd_exit = 0;
    n = 0;
    while (!ready && n < 100) begin n++; step(); end
    banks_idle = 1;
    sr_round("R1 R4 repeat");

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

endmodule